// File: doc/BRIEF.md
# Audio Front-End Serial Control Register

This block receives 16-bit control words over a three-wire serial link (frame enable, serial clock, serial data) and holds them in a register whose bits drive the mode pins of an analog audio front end: amplifier power enables, two mute controls, a record/playback select, a notch-frequency select, a 5-bit volume code and a low-power bias flag. The three serial lines are asynchronous to the block clock. They are resynchronised and edge-detected, so the serial clock is oversampled rather than used as a clock.

A start-up sequencer sits between the receiver and the register. On reset or standby release it starts a power-on pulse. When the pulse ends, the first complete frame is thrown away as a dummy and the second frame loads real data. Leaving bias mode works the same way. The frame that clears the bias bit is the dummy: it returns the outputs to the default word and starts a longer pulse, and the next complete frame after that pulse loads. Both pulse lengths are counted in block-clock cycles and are parameters. The control outputs are plain level signals, so there is no valid/ready stream and no back-pressure.

Top module: `afe_serial_ctl`

## Requirements
- R1: Serial data is sampled on each rising serial-clock edge while the frame enable is high. The first bit becomes control bit 0 and the sixteenth becomes bit 15. The word is applied in a single update after the frame enable falls.
- R2: A frame with any count of clock edges other than 16 is discarded and leaves every output unchanged.
- R3: Bit 0 drives `line_xtr_mute` and bit 1 drives `vref_chg_on`, both active high. Bit 8 drives `line_mute` (1 = muted).
- R4: Bits 2, 3, 6, 7 and 9 are active-low power controls. The outputs `mic_pwr_en`, `alc_pwr_en`, `rec_pwr_en`, `line_pwr_en` and `spk_pwr_en` are their inverses (bit = 0 gives enable = 1).
- R5: Bit 4 drives `rec_mode` (0 = playback, 1 = record). Bit 5 drives `notch_8k` (0 = 16 kHz notch, 1 = 8 kHz notch).
- R6: Bits 14 down to 10 form `vol_code`, with bit 10 as weight 1. Code 0 is minimum (mute) and code 31 is maximum.
- R7: Bit 15 drives `bias_mode` (0 = active, 1 = bias).
- R8: Reset, and the cycle after a synchronised low on `stby_n`, put the outputs at the default word 0x03EF: bits 0-3 and 5-9 set, all others clear.
- R9: After reset or standby release, frames that end within `POR_CYCLES` cycles are ignored. The first complete frame after that is a dummy that leaves the defaults in place. The next complete frame loads.
- R10: In bias mode, a complete frame with bit 15 = 0 returns the outputs to the default word and starts a `BIAS_CYCLES` pulse. Frames that end during that pulse are ignored. The first complete frame after the pulse loads.
- R11: Driving `stby_n` low at any time restarts the whole start-up sequence of R9.
- R12: In bias mode, a complete frame with bit 15 = 1 loads normally and the block stays in bias mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | 1 | Standby control, low = standby (asynchronous) |
| fr_en | input | 1 | Serial frame enable, high during a frame (asynchronous) |
| ser_clk | input | 1 | Serial clock (asynchronous, oversampled) |
| ser_dat | input | 1 | Serial data, LSB first |
| line_xtr_mute | output | 1 | Line-output mute transistor on |
| vref_chg_on | output | 1 | Reference capacitor fast-charge on |
| mic_pwr_en | output | 1 | Mic amplifier powered |
| alc_pwr_en | output | 1 | ALC amplifier powered |
| rec_mode | output | 1 | 1 = record path, 0 = playback |
| notch_8k | output | 1 | 1 = 8 kHz notch, 0 = 16 kHz notch |
| rec_pwr_en | output | 1 | Record amplifier powered |
| line_pwr_en | output | 1 | Line output powered |
| line_mute | output | 1 | Line output muted |
| spk_pwr_en | output | 1 | Speaker amplifier powered |
| vol_code | output | 5 | Volume code, 0 = mute, 31 = max |
| bias_mode | output | 1 | Low-power bias mode |

## Verification
The hardest situations to reach from the pins are frames that arrive inside a power-on pulse, and the exit from bias mode, where the dummy frame is also the frame that ends bias. The bench shortens both pulses through the parameters. It starts a frame right after reset, standby release or a bias-clearing frame, so that the frame ends while the pulse is still running. Frames with 15 and 17 clock edges are mixed in at each stage to show that only exact frames move the sequence forward. Randomly drawn words test each field.

// File: rtl/afe_ctl_pkg.sv
package afe_ctl_pkg;
  localparam int unsigned CTL_W = 16;

  // bit positions inside the control word
  localparam int unsigned B_XMUTE = 0;
  localparam int unsigned B_VCHG  = 1;
  localparam int unsigned B_MICP  = 2;
  localparam int unsigned B_ALCP  = 3;
  localparam int unsigned B_REC   = 4;
  localparam int unsigned B_NOTCH = 5;
  localparam int unsigned B_RECP  = 6;
  localparam int unsigned B_LINEP = 7;
  localparam int unsigned B_LMUTE = 8;
  localparam int unsigned B_SPKP  = 9;
  localparam int unsigned B_VOL   = 10;
  localparam int unsigned VOL_W   = 5;
  localparam int unsigned B_BIAS  = 15;

  localparam logic [CTL_W-1:0] CTL_DEFAULT = 16'h03EF;

  typedef enum logic [2:0] {
    S_PULSE,   // power-on pulse after reset/standby
    S_DUMMY,   // waiting for the dummy frame
    S_ARMED,   // next complete frame loads
    S_RUN,     // normal operation
    S_BIAS,    // bias (low-power) mode
    S_BPULSE   // pulse after leaving bias; dummy already consumed
  } seq_st_t;
endpackage

// File: rtl/afe_sync.sv
module afe_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/afe_ser_rx.sv
module afe_ser_rx #(
  parameter int unsigned DW = 16,
  localparam int unsigned CW = $clog2(DW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fr_en,
  input  logic          sck,
  input  logic          sdi,
  output logic          done,
  output logic          ok,
  output logic [DW-1:0] word
);
  localparam logic [CW-1:0] CNT_SAT = CW'(DW + 1);
  localparam logic [CW-1:0] CNT_OK  = CW'(DW);

  logic          en_d, sck_d;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      sck_d <= 1'b0;
      cnt   <= '0;
      sr    <= '0;
      done  <= 1'b0;
      ok    <= 1'b0;
      word  <= '0;
    end else begin
      en_d  <= fr_en;
      sck_d <= sck;
      done  <= 1'b0;
      if (fr_en && !en_d) begin
        cnt <= '0;
      end else if (fr_en && sck && !sck_d) begin
        sr <= {sdi, sr[DW-1:1]};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
      if (!fr_en && en_d) begin
        done <= 1'b1;
        ok   <= (cnt == CNT_OK);
        word <= sr;
      end
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_SAT);
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/afe_seq.sv
module afe_seq
  import afe_ctl_pkg::*;
#(
  parameter int unsigned POR_CYCLES  = 400000,
  parameter int unsigned BIAS_CYCLES = 1000000000,
  localparam int unsigned MAXC = (POR_CYCLES > BIAS_CYCLES) ? POR_CYCLES : BIAS_CYCLES,
  localparam int unsigned TW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_ok,
  input  logic frm_good,
  input  logic frm_bias,
  output logic load,
  output logic force_def,
  output logic hold
);
  localparam logic [TW-1:0] T_POR  = TW'(POR_CYCLES);
  localparam logic [TW-1:0] T_BIAS = TW'(BIAS_CYCLES);

  seq_st_t       st;
  logic [TW-1:0] tmr;
  logic          bias_exit;

  assign bias_exit = (st == S_BIAS) && frm_good && !frm_bias;
  assign load      = frm_good && ((st == S_ARMED) || (st == S_RUN) ||
                                  ((st == S_BIAS) && frm_bias));
  assign force_def = !stby_ok || bias_exit;
  assign hold      = (st == S_PULSE) || (st == S_BPULSE) ||
                     (st == S_DUMMY) || (st == S_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_PULSE;
      tmr <= T_POR;
    end else if (!stby_ok) begin
      st  <= S_PULSE;
      tmr <= T_POR;
    end else begin
      unique case (st)
        S_PULSE, S_BPULSE: begin
          if (tmr == '0) st <= (st == S_PULSE) ? S_DUMMY : S_ARMED;
          else           tmr <= tmr - 1'b1;
        end
        S_DUMMY: if (frm_good) st <= S_ARMED;
        S_ARMED, S_RUN: if (frm_good) st <= frm_bias ? S_BIAS : S_RUN;
        S_BIAS: begin
          if (bias_exit) begin
            st  <= S_BPULSE;
            tmr <= T_BIAS;
          end
        end
        default: st <= S_PULSE;
      endcase
    end
  end

  p_stby_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_ok |=> (st == S_PULSE));
  p_no_load_in_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_PULSE) || (st == S_BPULSE) || (st == S_DUMMY)) |-> !load);
  p_bias_exit_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_ok && bias_exit) |=> (st == S_BPULSE));
endmodule

// File: rtl/afe_serial_ctl.sv
module afe_serial_ctl
  import afe_ctl_pkg::*;
#(
  parameter int unsigned POR_CYCLES  = 400000,
  parameter int unsigned BIAS_CYCLES = 1000000000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_n,
  input  logic       fr_en,
  input  logic       ser_clk,
  input  logic       ser_dat,
  output logic       line_xtr_mute,
  output logic       vref_chg_on,
  output logic       mic_pwr_en,
  output logic       alc_pwr_en,
  output logic       rec_mode,
  output logic       notch_8k,
  output logic       rec_pwr_en,
  output logic       line_pwr_en,
  output logic       line_mute,
  output logic       spk_pwr_en,
  output logic [4:0] vol_code,
  output logic       bias_mode
);
  logic [3:0]       pins_s;
  logic             rx_done, rx_ok;
  logic [CTL_W-1:0] rx_word;
  logic             load, force_def, hold;
  logic [CTL_W-1:0] ctl_q;

  afe_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({stby_n, fr_en, ser_clk, ser_dat}),
    .q   (pins_s)
  );

  afe_ser_rx #(.DW(CTL_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .fr_en (pins_s[2]),
    .sck   (pins_s[1]),
    .sdi   (pins_s[0]),
    .done  (rx_done),
    .ok    (rx_ok),
    .word  (rx_word)
  );

  afe_seq #(.POR_CYCLES(POR_CYCLES), .BIAS_CYCLES(BIAS_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby_ok   (pins_s[3]),
    .frm_good  (rx_done && rx_ok),
    .frm_bias  (rx_word[B_BIAS]),
    .load      (load),
    .force_def (force_def),
    .hold      (hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctl_q <= CTL_DEFAULT;
    else if (force_def) ctl_q <= CTL_DEFAULT;
    else if (load)      ctl_q <= rx_word;
  end

  assign line_xtr_mute = ctl_q[B_XMUTE];
  assign vref_chg_on   = ctl_q[B_VCHG];
  assign mic_pwr_en    = ~ctl_q[B_MICP];
  assign alc_pwr_en    = ~ctl_q[B_ALCP];
  assign rec_mode      = ctl_q[B_REC];
  assign notch_8k      = ctl_q[B_NOTCH];
  assign rec_pwr_en    = ~ctl_q[B_RECP];
  assign line_pwr_en   = ~ctl_q[B_LINEP];
  assign line_mute     = ctl_q[B_LMUTE];
  assign spk_pwr_en    = ~ctl_q[B_SPKP];
  assign vol_code      = ctl_q[B_VOL +: VOL_W];
  assign bias_mode     = ctl_q[B_BIAS];

  p_hold_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (ctl_q == CTL_DEFAULT));
  p_stable_no_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || force_def) |=> $stable(ctl_q));
  p_load_takes_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !force_def) |=> (ctl_q == $past(rx_word)));
endmodule

// File: tb/tb_afe_serial_ctl.sv
module tb_afe_serial_ctl;
  localparam int POR_C  = 300;
  localparam int BIAS_C = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0, stby_n = 1'b1, fr_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic line_xtr_mute, vref_chg_on, mic_pwr_en, alc_pwr_en, rec_mode, notch_8k;
  logic rec_pwr_en, line_pwr_en, line_mute, spk_pwr_en, bias_mode;
  logic [4:0] vol_code;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  afe_serial_ctl #(.POR_CYCLES(POR_C), .BIAS_CYCLES(BIAS_C)) dut (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .fr_en(fr_en),
    .ser_clk(ser_clk), .ser_dat(ser_dat),
    .line_xtr_mute(line_xtr_mute), .vref_chg_on(vref_chg_on),
    .mic_pwr_en(mic_pwr_en), .alc_pwr_en(alc_pwr_en), .rec_mode(rec_mode),
    .notch_8k(notch_8k), .rec_pwr_en(rec_pwr_en), .line_pwr_en(line_pwr_en),
    .line_mute(line_mute), .spk_pwr_en(spk_pwr_en), .vol_code(vol_code),
    .bias_mode(bias_mode)
  );

  localparam logic [15:0] DEF = 16'h03EF;

  // rebuild the raw word from the output pins (R3..R7 polarity)
  function automatic logic [15:0] pins_word();
    return {bias_mode, vol_code, ~spk_pwr_en, line_mute, ~line_pwr_en,
            ~rec_pwr_en, notch_8k, rec_mode, ~alc_pwr_en, ~mic_pwr_en,
            vref_chg_on, line_xtr_mute};
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_fields(input logic [15:0] w);
    chk("R3 xtr mute", 16'(line_xtr_mute), 16'(w[0]));
    chk("R3 vref chg", 16'(vref_chg_on), 16'(w[1]));
    chk("R3 line mute", 16'(line_mute), 16'(w[8]));
    chk("R4 power enables", {11'd0, mic_pwr_en, alc_pwr_en, rec_pwr_en, line_pwr_en, spk_pwr_en},
        {11'd0, ~w[2], ~w[3], ~w[6], ~w[7], ~w[9]});
    chk("R5 rec/notch", {14'd0, rec_mode, notch_8k}, {14'd0, w[4], w[5]});
    chk("R6 volume", 16'(vol_code), 16'(w[14:10]));
    chk("R7 bias", 16'(bias_mode), 16'(w[15]));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    fr_en = 1'b1;
    cyc(8);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = w[i % 16];
      cyc(4);
      ser_clk = 1'b1;
      cyc(4);
      ser_clk = 1'b0;
    end
    cyc(4);
    fr_en = 1'b0;
    cyc(12);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] w, prev;
    void'($urandom(32'd7321));
    cyc(5);
    chk("R8 reset default", pins_word(), DEF);
    rst_n = 1'b1;
    // frame ending inside the power-on pulse is ignored (R9)
    send(16'h1234, 16);
    chk("R9 frame in pulse ignored", pins_word(), DEF);
    cyc(POR_C);
    send(16'h5A5A, 16);                     // dummy
    chk("R9 dummy ignored", pins_word(), DEF);
    send(16'h0F0F, 15);                     // short frame while armed
    chk("R2 short frame while armed", pins_word(), DEF);
    w = 16'h1C52;
    send(w, 16);
    chk("R9 second frame loads / R1", pins_word(), w);
    chk_fields(w);
    // random words, bias bit clear
    for (int k = 0; k < 24; k++) begin
      w = 16'($urandom) & 16'h7FFF;
      send(w, 16);
      chk("R1 random load", pins_word(), w);
      chk_fields(w);
    end
    prev = w;
    send(16'h7FFF, 17);
    chk("R2 long frame discarded", pins_word(), prev);
    send(16'h0000, 3);
    chk("R2 short frame discarded", pins_word(), prev);
    send(16'h0000, 16);
    chk("R6 volume min", 16'(vol_code), 16'd0);
    send(16'h7C00, 16);
    chk("R6 volume max", 16'(vol_code), 16'd31);
    // bias entry and re-load in bias
    w = 16'h8123;
    send(w, 16);
    chk("R7 enter bias", pins_word(), w);
    w = 16'hC6A9;
    send(w, 16);
    chk("R12 load in bias", pins_word(), w);
    // bias exit
    send(16'h2468, 16);
    chk("R10 exit returns default", pins_word(), DEF);
    send(16'h1357, 16);
    chk("R10 frame in bias pulse ignored", pins_word(), DEF);
    cyc(BIAS_C);
    w = 16'h3A17;
    send(w, 16);
    chk("R10 first frame after pulse loads", pins_word(), w);
    // standby restart
    stby_n = 1'b0;
    cyc(10);
    chk("R11 standby default", pins_word(), DEF);
    stby_n = 1'b1;
    cyc(POR_C + 10);
    send(16'h0001, 16);
    chk("R11 dummy after standby", pins_word(), DEF);
    w = 16'(16'($urandom) & 16'h7FFF);
    send(w, 16);
    chk("R11 load after restart", pins_word(), w);
    chk_fields(w);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule